// File: doc/BRIEF.md
# Dual-Half Timer with Capture and Interrupt Flags

This block is a 16-bit counter that can run in two arrangements. In wide arrangement it counts as a single 16-bit value. In split arrangement it counts as two independent 8-bit halves, called high and low. Each arrangement offers a free-running timer behaviour or an input-capture behaviour. In capture behaviour, a rising edge on an asynchronous strobe copies the counter into capture registers that software can read.

The counter advances only on cycles where a shared clock-select enable is high. The block keeps two sticky event flags, one for each half. Software clears a flag by writing a one to it. The two flags are merged into a single interrupt line. The low flag reaches that line only while its local enable is set.

In wide capture behaviour the two flags report different kinds of event. The high flag marks a completed capture. The low flag marks a wrap of the full 16-bit count, which tells software that the counter rolled over between two captures.

Top module: `dual_half_timer`

## Requirements
- R1: While rst_ni is low, and after it is released, cnt_o, cap_hi_o, cap_lo_o, flags_o and irq_o are all zero.
- R2: In wide arrangement (split_i=0), cnt_o increments by one, wrapping from 16'hFFFF to 0, on each clock edge where tick_i=1 and hi_run_i=1. lo_run_i has no effect in this arrangement, and the count holds when tick_i=0.
- R3: In split arrangement (split_i=1), cnt_o[7:0] and cnt_o[15:8] count as two independent 8-bit counters. Each advances on tick_i together with its own run bit (lo_run_i or hi_run_i). No carry passes from the low half to the high half.
- R4: In wide timer behaviour (split_i=0, hi_cap_i=0), the increment from 16'hFFFF sets flags_o[1]. Every low-byte wrap from 8'hFF sets flags_o[0].
- R5: In wide capture behaviour (split_i=0, hi_cap_i=1), a capture event copies cnt_o[15:8] into cap_hi_o and cnt_o[7:0] into cap_lo_o, and sets flags_o[1]. flags_o[0] sets only on the 16-bit wrap from 16'hFFFF. Low-byte wraps do not set it.
- R6: In split arrangement, each half sets its own flag independently (flags_o[1] for high, flags_o[0] for low). A half whose capture bit (hi_cap_i or lo_cap_i) is 1 sets its flag on a capture event and latches only its own byte. A half whose capture bit is 0 sets its flag when its 8-bit count wraps.
- R7: cap_i passes through two synchronizer flops and then an edge detector. Suppose cap_i rises between two clock edges. The capture registers and flags then update at the third rising clock edge after the change, using the count value that stood just before that edge. Holding cap_i high does not capture again.
- R8: Flags are sticky. Writing clr_i[1] or clr_i[0] as 1 clears flags_o[1] or flags_o[0] on the next edge. If a set event arrives in the same cycle as a clear, the flag stays set.
- R9: irq_o equals flags_o[1] OR (flags_o[0] AND lo_irq_en_i).
- R10: A capture register is unchanged by a capture event when its half is not in capture behaviour. In wide arrangement only hi_cap_i selects capture behaviour, and lo_cap_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable from the shared clock select |
| split_i | input | 1 | 1 = two 8-bit halves, 0 = one 16-bit counter |
| hi_run_i | input | 1 | Run for the high half (gates the whole counter in wide arrangement) |
| lo_run_i | input | 1 | Run for the low half (used in split arrangement only) |
| hi_cap_i | input | 1 | Capture behaviour for the high half (the whole counter in wide arrangement) |
| lo_cap_i | input | 1 | Capture behaviour for the low half (used in split arrangement only) |
| cap_i | input | 1 | Asynchronous capture strobe, active on its rising edge |
| lo_irq_en_i | input | 1 | Lets flags_o[0] drive irq_o |
| clr_i | input | 2 | Write-one-to-clear for the flags: bit 1 high, bit 0 low |
| cnt_o | output | 16 | Current count, with the high half in the upper byte |
| cap_hi_o | output | 8 | Captured high byte |
| cap_lo_o | output | 8 | Captured low byte |
| flags_o | output | 2 | Sticky flags: bit 1 high, bit 0 low |
| irq_o | output | 1 | Combined interrupt |

## Verification
A long directed wide-timer run reaches both the low-byte wrap and the full 16-bit wrap. This shows which flag each wrap sets. The same capture pulse is then applied in wide timer, wide capture and split behaviour with mixed capture bits. That shows whether a capture latches both bytes, one byte or nothing, and which flag it raises. Random phases then toggle tick, run bits, split, capture strobe, clears and the low enable every cycle. These phases catch cross-half carries, lost set-versus-clear priority and interrupt masking errors, all checked against a cycle model kept in the bench.

// File: rtl/dht_pkg.sv
package dht_pkg;
  localparam int unsigned HALVES = 2;
  localparam int unsigned LO     = 0;
  localparam int unsigned HI     = 1;
endpackage

// File: rtl/dht_sync.sv
module dht_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh <= '0;
    else         sh <= {sh[STAGES-1:0], d_i};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/dht_count.sv
module dht_count
  import dht_pkg::*;
#(
  parameter int unsigned HALF_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_i,
  input  logic                       split_i,
  input  logic [HALVES-1:0]          run_i,
  output logic [HALVES*HALF_W-1:0]   cnt_o,
  output logic [HALVES-1:0]          wrap_o
);
  logic [HALVES-1:0][HALF_W-1:0] half_q;
  logic [HALVES-1:0]             adv, at_max;

  for (genvar g = 0; g < HALVES; g++) begin : g_max
    assign at_max[g] = &half_q[g];
  end

  // wide: high half run gates both bytes, low carry feeds high
  assign adv[LO] = tick_i & (split_i ? run_i[LO] : run_i[HI]);
  assign adv[HI] = tick_i & run_i[HI] & (split_i | at_max[LO]);
  assign wrap_o  = adv & at_max;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= '0;
    end else begin
      for (int i = 0; i < HALVES; i++)
        if (adv[i]) half_q[i] <= half_q[i] + 1'b1;
    end
  end

  assign cnt_o = half_q;
endmodule

// File: rtl/dht_flags.sv
module dht_flags
  import dht_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALVES-1:0] set_i,
  input  logic [HALVES-1:0] clr_i,
  output logic [HALVES-1:0] flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (flags_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/dual_half_timer.sv
module dual_half_timer
  import dht_pkg::*;
#(
  parameter int unsigned HALF_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = HALVES * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              split_i,
  input  logic              hi_run_i,
  input  logic              lo_run_i,
  input  logic              hi_cap_i,
  input  logic              lo_cap_i,
  input  logic              cap_i,
  input  logic              lo_irq_en_i,
  input  logic [1:0]        clr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [HALF_W-1:0] cap_hi_o,
  output logic [HALF_W-1:0] cap_lo_o,
  output logic [1:0]        flags_o,
  output logic              irq_o
);
  logic                          cap_evt;
  logic [HALVES-1:0]             wrap, latch, set;
  logic [HALVES-1:0][HALF_W-1:0] cap_q;
  logic [HALVES-1:0][HALF_W-1:0] cnt_halves;

  dht_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cap_i),
    .rise_o (cap_evt)
  );

  dht_count #(.HALF_W(HALF_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .split_i (split_i),
    .run_i   ({hi_run_i, lo_run_i}),
    .cnt_o   (cnt_o),
    .wrap_o  (wrap)
  );

  assign cnt_halves = cnt_o;

  // wide: hi_cap_i selects capture for the whole counter
  assign latch[HI] = cap_evt & hi_cap_i;
  assign latch[LO] = cap_evt & (split_i ? lo_cap_i : hi_cap_i);

  // wide timer: hi on 16-bit wrap; wide capture: hi on capture, lo on 16-bit wrap
  assign set[HI] = hi_cap_i ? cap_evt : wrap[HI];
  assign set[LO] = split_i ? (lo_cap_i ? cap_evt : wrap[LO])
                           : (hi_cap_i ? wrap[HI] : wrap[LO]);

  for (genvar g = 0; g < HALVES; g++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cap_q[g] <= '0;
      else if (latch[g]) cap_q[g] <= cnt_halves[g];
    end
  end

  dht_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set),
    .clr_i   (clr_i),
    .flags_o (flags_o)
  );

  assign cap_hi_o = cap_q[HI];
  assign cap_lo_o = cap_q[LO];
  assign irq_o    = flags_o[HI] | (flags_o[LO] & lo_irq_en_i);
endmodule

// File: rtl/dht_chk.sv
module dht_chk #(
  parameter int unsigned HALF_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = 2 * HALF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              split_i,
  input logic              hi_run_i,
  input logic              lo_run_i,
  input logic              hi_cap_i,
  input logic              lo_cap_i,
  input logic              cap_i,
  input logic              lo_irq_en_i,
  input logic [1:0]        clr_i,
  input logic [CNT_W-1:0]  cnt_o,
  input logic [HALF_W-1:0] cap_hi_o,
  input logic [HALF_W-1:0] cap_lo_o,
  input logic [1:0]        flags_o,
  input logic              irq_o
);
  // R9
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lo_irq_en_i && !flags_o[1]) |-> !irq_o);
  // R9
  irq_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[1] |-> irq_o);
  // R2
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
  // R8
  hi_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[1] && !clr_i[1]) |=> flags_o[1]);
  // R8
  lo_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[0] && !clr_i[0]) |=> flags_o[0]);
  // R10
  cap_hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_cap_i |=> $stable(cap_hi_o));
  // R4
  wide_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!split_i && !hi_cap_i && hi_run_i && tick_i && cnt_o == {CNT_W{1'b1}})
      |=> (flags_o[1] && cnt_o == '0));
  // R5
  wide_cap_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!split_i && hi_cap_i && hi_run_i && tick_i && cnt_o == {CNT_W{1'b1}})
      |=> flags_o[0]);
  // R3
  split_lo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split_i && !lo_run_i) |=> $stable(cnt_o[HALF_W-1:0]));
endmodule

bind dual_half_timer dht_chk #(.HALF_W(HALF_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/tb_dual_half_timer.sv
module tb_dual_half_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 0, split = 0, hi_run = 0, lo_run = 0;
  logic        hi_cap = 0, lo_cap = 0, cap = 0, lo_en = 0;
  logic [1:0]  clr = '0;
  logic [15:0] cnt;
  logic [7:0]  cap_hi, cap_lo;
  logic [1:0]  flags;
  logic        irq;

  int unsigned vecs = 0, errs = 0;
  bit          done = 0;

  // bench model state
  logic [15:0] m_cnt = '0;
  logic [7:0]  m_ch = '0, m_cl = '0;
  logic [1:0]  m_fl = '0;
  logic        m_s1 = 0, m_s2 = 0, m_s3 = 0;

  always #5 clk = ~clk;

  dual_half_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .split_i(split),
    .hi_run_i(hi_run), .lo_run_i(lo_run), .hi_cap_i(hi_cap), .lo_cap_i(lo_cap),
    .cap_i(cap), .lo_irq_en_i(lo_en), .clr_i(clr), .cnt_o(cnt),
    .cap_hi_o(cap_hi), .cap_lo_o(cap_lo), .flags_o(flags), .irq_o(irq)
  );

  function automatic logic exp_irq(logic [1:0] f, logic en);
    return f[1] | (f[0] & en);
  endfunction

  function automatic string mode_tag();
    if (split) return "R6";
    return hi_cap ? "R5" : "R4";
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s at %0t: got %0h expected %0h", req, $time, got, exp);
    end
  endtask

  // one clock edge of the requirement-level model
  task automatic model_edge();
    logic evt, lo_adv, hi_adv, lo_wr, hi_wr;
    logic [1:0] set;
    evt    = m_s2 & ~m_s3;
    lo_adv = tick & (split ? lo_run : hi_run);
    hi_adv = tick & hi_run & (split | (m_cnt[7:0] == 8'hFF));
    lo_wr  = lo_adv & (m_cnt[7:0] == 8'hFF);
    hi_wr  = hi_adv & (m_cnt[15:8] == 8'hFF);
    set[1] = hi_cap ? evt : hi_wr;
    set[0] = split ? (lo_cap ? evt : lo_wr) : (hi_cap ? hi_wr : lo_wr);
    if (evt && hi_cap) m_ch = m_cnt[15:8];
    if (evt && (split ? lo_cap : hi_cap)) m_cl = m_cnt[7:0];
    if (lo_adv) m_cnt[7:0]  = m_cnt[7:0] + 8'd1;
    if (hi_adv) m_cnt[15:8] = m_cnt[15:8] + 8'd1;
    m_fl = (m_fl & ~clr) | set;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap;
  endtask

  task automatic step();
    string t;
    @(posedge clk);
    t = mode_tag();
    model_edge();
    #1;
    chk(split ? "R3" : "R2", cnt, m_cnt);
    chk("R7/R10 cap_hi", cap_hi, m_ch);
    chk("R7/R10 cap_lo", cap_lo, m_cl);
    chk({t, "/R8 flags"}, flags, m_fl);
    chk("R9", irq, exp_irq(m_fl, lo_en));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse_cap();
    cap = 1; run(2); cap = 0; run(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    #23;
    chk("R1 cnt in reset", cnt, 0);
    chk("R1 flags in reset", flags, 0);
    chk("R1 irq in reset", irq, 0);
    #4 rst_n = 1'b1;
    step();
    chk("R1 caps after reset", {cap_hi, cap_lo}, 0);

    // wide timer: low wrap, then full 16-bit wrap
    tick = 1; hi_run = 1; lo_run = 0; lo_en = 1;
    run(300);
    chk("R4 low byte wrap flag", flags[0], 1);
    clr = 2'b01; step(); clr = 2'b00;
    chk("R8 low flag cleared", flags[0], 0);
    lo_en = 0;
    run(65300);
    chk("R4 16-bit wrap flag", flags[1], 1);
    clr = 2'b11; step(); clr = 2'b00;
    chk("R8 both cleared", flags, 0);

    // R10: lo_cap ignored in wide timer
    lo_cap = 1; pulse_cap();
    chk("R10 no capture in wide timer", {cap_hi, cap_lo}, 0);

    // R5: wide capture latches both bytes and sets the high flag
    hi_cap = 1; lo_cap = 0; pulse_cap();
    chk("R5 capture flag", flags[1], 1);
    chk("R7 held level no recapture", cap, 0);
    cap = 1; run(10); cap = 0; run(3);

    // split arrangement, mixed capture bits
    clr = 2'b11; step(); clr = 0;
    split = 1; lo_run = 1; hi_run = 0; hi_cap = 0; lo_cap = 1;
    run(260);
    pulse_cap();
    chk("R6 low half captured", flags[0], 1);
    hi_run = 1; hi_cap = 1; lo_cap = 0; run(300);
    pulse_cap();

    // random phase
    for (int i = 0; i < 30000; i++) begin
      tick   = ($urandom_range(3) != 0);
      hi_run = ($urandom_range(7) != 0);
      lo_run = ($urandom_range(7) != 0);
      if ($urandom_range(199) == 0) split  = ~split;
      if ($urandom_range(99) == 0)  hi_cap = ~hi_cap;
      if ($urandom_range(99) == 0)  lo_cap = ~lo_cap;
      if ($urandom_range(5) == 0)   cap    = ~cap;
      lo_en = ($urandom_range(1) != 0);
      clr   = ($urandom_range(9) == 0) ? 2'($urandom_range(3)) : 2'b00;
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule